// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the scan timing for a display output: a pixel counter, a line counter, a data-enable strobe, horizontal, vertical and composite sync, a field indicator and a one-cycle pulse at the start of every field. The raster origin is the first active pixel of the first active line. Each line runs through its active pixels, then the right margin, the horizontal sync and the left margin. Each field runs through its active lines, then the bottom margin, the vertical sync and the top margin.

Software programs four packed 32-bit words and a few control bits. Every word holds its vertical value in bits [31:16] and its horizontal value in bits [15:0]. The words are the active size, the totals, the horizontal margins and the vertical margins. The vertical values are per-field values, so an interlaced frame of 1080 lines is programmed as 540 active lines. With interlace enabled the generator alternates between an even field and an odd field. The odd field is one line longer, and its vertical sync starts one line later and half a line earlier in the line. The two shifts together place that edge mid-line. The field parameters are latched only at a field boundary, so a reprogram never produces a torn field.

Top module: `ilace_raster_gen`

## Requirements
- R1: While `rst` is high, both counters and every output are 0. On the first cycle after release, the outputs describe position (0,0) of an even field.
- R2: All outputs are registered and describe the same raster position (`o_hcnt`, `o_vcnt`). The pixel count runs from 0 to htotal-1, where htotal is `cfg_total[15:0]`. The line count advances when the pixel count wraps and returns to 0 after the field's last line.
- R3: `o_de` is 1 exactly when pixel < hactive (`cfg_active[15:0]`) and line < vactive (`cfg_active[31:16]`).
- R4: Horizontal sync is active for hsync_start ≤ pixel < hsync_end. Here hsync_start = hactive + right margin (`cfg_hporch[15:0]`) and hsync_end = htotal − left margin (`cfg_hporch[31:16]`).
- R5: In an even field, the field has vtotal lines (`cfg_total[31:16]`). Vertical sync becomes active at (line vsync_start, pixel hsync_start) and goes inactive at (line vsync_end, pixel hsync_start). Here vsync_start = vactive + bottom margin (`cfg_vporch[15:0]`) and vsync_end = vtotal − top margin (`cfg_vporch[31:16]`).
- R6: In an odd field the total, vsync_start and vsync_end are each one line greater than in an even field, so the top margin is unchanged. Both vertical sync edges fall at pixel hsync_start − htotal/2 (htotal/2 rounded down).
- R7: With `cfg_ilace` = 1, fields alternate even, odd, even and so on, starting even after reset. With `cfg_ilace` = 0 every field is even. `o_field` is 0 for even and 1 for odd.
- R8: `o_sof_even` or `o_sof_odd`, whichever matches the field, is high for one cycle at position (0,0) of every field and at no other time.
- R9: The syncs are active high. Setting `cfg_inv_hs`, `cfg_inv_vs` or `cfg_inv_cs` makes that output active low. Composite sync is active while either horizontal or vertical sync is active.
- R10: Changes to the timing words or to `cfg_ilace` take effect only at the next field boundary. The field in progress keeps its length and sync placement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active | input | 32 | {vactive, hactive} per field |
| cfg_total | input | 32 | {vtotal even field, htotal} |
| cfg_hporch | input | 32 | {left margin, right margin} |
| cfg_vporch | input | 32 | {top margin, bottom margin} |
| cfg_ilace | input | 1 | Interlace enable |
| cfg_inv_hs | input | 1 | Horizontal sync active low |
| cfg_inv_vs | input | 1 | Vertical sync active low |
| cfg_inv_cs | input | 1 | Composite sync active low |
| o_hcnt | output | HW | Pixel position |
| o_vcnt | output | VW | Line position within field |
| o_de | output | 1 | Data enable |
| o_hsync | output | 1 | Horizontal sync |
| o_vsync | output | 1 | Vertical sync |
| o_csync | output | 1 | Composite sync |
| o_field | output | 1 | Field indicator, 1 = odd |
| o_sof_even | output | 1 | Start of even field pulse |
| o_sof_odd | output | 1 | Start of odd field pulse |

## Verification
The bench builds the block with the default widths, HW = 12 and VW = 11. These widths cover a 2640-clock line and a 563-line odd field. The programmed raster is a tiny one of 16 clocks by 10 lines, so every field boundary and every sync edge falls within a few hundred cycles. That makes it practical to cover many even/odd alternations, mid-field reprogramming of the margins and the interlace bit, polarity flips and a reset during interlaced running. The odd-field sync pixel (hsync_start − 8) and the field lengths of 160 and 176 clocks are checked against the programmed values.

// File: rtl/itg_pkg.sv
package itg_pkg;
  localparam int CFG_W    = 32;
  localparam int CFG_HALF = 16;

  typedef enum logic {
    FLD_EVEN = 1'b0,
    FLD_ODD  = 1'b1
  } field_e;
endpackage

// File: rtl/itg_field_ctl.sv
module itg_field_ctl
  import itg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_active,
  input  logic [CFG_W-1:0] cfg_total,
  input  logic [CFG_W-1:0] cfg_hporch,
  input  logic [CFG_W-1:0] cfg_vporch,
  input  logic             cfg_ilace,
  input  logic             field_end,
  output logic [HW-1:0]    hact,
  output logic [HW-1:0]    htot,
  output logic [HW-1:0]    hs_s,
  output logic [HW-1:0]    hs_e,
  output logic [HW-1:0]    vpos,
  output logic [VW-1:0]    vact,
  output logic [VW-1:0]    vtot,
  output logic [VW-1:0]    vs_s,
  output logic [VW-1:0]    vs_e,
  output field_e           field
);
  // Fields of the packed words: horizontal low half, vertical high half
  logic [HW-1:0] c_hact, c_htot, c_right, c_left, c_hss, c_hse, c_half, c_vpos;
  logic [VW-1:0] c_vact, c_vtot, c_bot, c_top, c_vss, c_vse, c_odd_inc;
  field_e        nxt_field;
  logic          load;

  assign c_hact  = cfg_active[HW-1:0];
  assign c_vact  = cfg_active[CFG_HALF +: VW];
  assign c_htot  = cfg_total[HW-1:0];
  assign c_right = cfg_hporch[HW-1:0];
  assign c_left  = cfg_hporch[CFG_HALF +: HW];
  assign c_bot   = cfg_vporch[VW-1:0];
  assign c_top   = cfg_vporch[CFG_HALF +: VW];

  // Parity of the field about to start
  always_comb begin
    if (rst)
      nxt_field = FLD_EVEN;
    else if (cfg_ilace && field == FLD_EVEN)
      nxt_field = FLD_ODD;
    else
      nxt_field = FLD_EVEN;
  end

  assign c_odd_inc = {{(VW-1){1'b0}}, (nxt_field == FLD_ODD)};
  assign c_half    = c_htot >> 1;
  assign c_hss     = c_hact + c_right;
  assign c_hse     = c_htot - c_left;
  assign c_vtot    = cfg_total[CFG_HALF +: VW] + c_odd_inc;
  assign c_vss     = c_vact + c_bot + c_odd_inc;
  assign c_vse     = c_vtot - c_top;
  assign c_vpos    = (nxt_field == FLD_ODD) ? (c_hss - c_half) : c_hss;

  assign load = rst || field_end;

  always_ff @(posedge clk) begin
    if (load) begin
      hact  <= c_hact;
      htot  <= c_htot;
      hs_s  <= c_hss;
      hs_e  <= c_hse;
      vpos  <= c_vpos;
      vact  <= c_vact;
      vtot  <= c_vtot;
      vs_s  <= c_vss;
      vs_e  <= c_vse;
      field <= nxt_field;
    end
  end
endmodule

// File: rtl/itg_counters.sv
module itg_counters #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] htot,
  input  logic [VW-1:0] vtot,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          field_end
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic line_end;

  assign line_end  = (hcnt == htot - H_ONE);
  assign field_end = line_end && (vcnt == vtot - V_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= field_end ? '0 : vcnt + V_ONE;
    end else begin
      hcnt <= hcnt + H_ONE;
    end
  end
endmodule

// File: rtl/itg_sync_gen.sv
module itg_sync_gen
  import itg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [HW-1:0] hact,
  input  logic [HW-1:0] hs_s,
  input  logic [HW-1:0] hs_e,
  input  logic [HW-1:0] vpos,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vs_s,
  input  logic [VW-1:0] vs_e,
  input  field_e        field,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_cs,
  output logic [HW-1:0] o_hcnt,
  output logic [VW-1:0] o_vcnt,
  output logic          o_de,
  output logic          o_hsync,
  output logic          o_vsync,
  output logic          o_csync,
  output logic          o_field,
  output logic          o_sof_even,
  output logic          o_sof_odd
);
  logic in_de, in_hs, in_vs, vs_past_start, vs_before_end, at_origin;

  assign in_de         = (hcnt < hact) && (vcnt < vact);
  assign in_hs         = (hcnt >= hs_s) && (hcnt < hs_e);
  assign vs_past_start = (vcnt > vs_s) || ((vcnt == vs_s) && (hcnt >= vpos));
  assign vs_before_end = (vcnt < vs_e) || ((vcnt == vs_e) && (hcnt < vpos));
  assign in_vs         = vs_past_start && vs_before_end;
  assign at_origin     = (hcnt == '0) && (vcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_hcnt     <= '0;
      o_vcnt     <= '0;
      o_de       <= 1'b0;
      o_hsync    <= 1'b0;
      o_vsync    <= 1'b0;
      o_csync    <= 1'b0;
      o_field    <= 1'b0;
      o_sof_even <= 1'b0;
      o_sof_odd  <= 1'b0;
    end else begin
      o_hcnt     <= hcnt;
      o_vcnt     <= vcnt;
      o_de       <= in_de;
      o_hsync    <= in_hs ^ inv_hs;
      o_vsync    <= in_vs ^ inv_vs;
      o_csync    <= (in_hs | in_vs) ^ inv_cs;
      o_field    <= (field == FLD_ODD);
      o_sof_even <= at_origin && (field == FLD_EVEN);
      o_sof_odd  <= at_origin && (field == FLD_ODD);
    end
  end
endmodule

// File: rtl/ilace_raster_gen.sv
module ilace_raster_gen
  import itg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   cfg_active,
  input  logic [31:0]   cfg_total,
  input  logic [31:0]   cfg_hporch,
  input  logic [31:0]   cfg_vporch,
  input  logic          cfg_ilace,
  input  logic          cfg_inv_hs,
  input  logic          cfg_inv_vs,
  input  logic          cfg_inv_cs,
  output logic [HW-1:0] o_hcnt,
  output logic [VW-1:0] o_vcnt,
  output logic          o_de,
  output logic          o_hsync,
  output logic          o_vsync,
  output logic          o_csync,
  output logic          o_field,
  output logic          o_sof_even,
  output logic          o_sof_odd
);
  logic [HW-1:0] cur_hact, cur_htot, cur_hss, cur_hse, cur_vpos, hcnt;
  logic [VW-1:0] cur_vact, cur_vtot, cur_vss, cur_vse, vcnt;
  field_e        cur_field;
  logic          field_end;

  itg_field_ctl #(.HW(HW), .VW(VW)) u_fld (
    .clk(clk), .rst(rst),
    .cfg_active(cfg_active), .cfg_total(cfg_total),
    .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch),
    .cfg_ilace(cfg_ilace), .field_end(field_end),
    .hact(cur_hact), .htot(cur_htot), .hs_s(cur_hss), .hs_e(cur_hse),
    .vpos(cur_vpos), .vact(cur_vact), .vtot(cur_vtot), .vs_s(cur_vss),
    .vs_e(cur_vse), .field(cur_field)
  );

  itg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .htot(cur_htot), .vtot(cur_vtot),
    .hcnt(hcnt), .vcnt(vcnt), .field_end(field_end)
  );

  itg_sync_gen #(.HW(HW), .VW(VW)) u_sync (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hact(cur_hact), .hs_s(cur_hss), .hs_e(cur_hse), .vpos(cur_vpos),
    .vact(cur_vact), .vs_s(cur_vss), .vs_e(cur_vse), .field(cur_field),
    .inv_hs(cfg_inv_hs), .inv_vs(cfg_inv_vs), .inv_cs(cfg_inv_cs),
    .o_hcnt(o_hcnt), .o_vcnt(o_vcnt), .o_de(o_de), .o_hsync(o_hsync),
    .o_vsync(o_vsync), .o_csync(o_csync), .o_field(o_field),
    .o_sof_even(o_sof_even), .o_sof_odd(o_sof_odd)
  );
endmodule

// File: rtl/ilace_raster_gen_chk.sv
module ilace_raster_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] o_hcnt,
  input logic [VW-1:0] o_vcnt,
  input logic          o_de,
  input logic          o_hsync,
  input logic          o_vsync,
  input logic          o_csync,
  input logic          o_field,
  input logic          o_sof_even,
  input logic          o_sof_odd,
  input logic          inv_hs,
  input logic          inv_vs,
  input logic          inv_cs,
  input logic [HW-1:0] cur_hact,
  input logic [VW-1:0] cur_vact
);
  // R2: pixel count steps by one except where it wraps to zero
  a_r2_hcnt_step: assert property (@(posedge clk) disable iff (rst)
    (o_hcnt != '0) |-> (o_hcnt == $past(o_hcnt) + HW'(1)));

  // R2: line count only moves when the pixel count wraps
  a_r2_vcnt_hold: assert property (@(posedge clk) disable iff (rst)
    (o_hcnt != '0) |-> $stable(o_vcnt));

  // R3: data enable only inside the latched active window
  a_r3_de_window: assert property (@(posedge clk) disable iff (rst)
    o_de |-> ((o_hcnt < cur_hact) && (o_vcnt < cur_vact)));

  // R8: at most one field-start pulse, only at the origin
  a_r8_sof_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({o_sof_even, o_sof_odd}));

  a_r8_sof_origin: assert property (@(posedge clk) disable iff (rst)
    (o_sof_even || o_sof_odd) |-> ((o_hcnt == '0) && (o_vcnt == '0)));

  // R7: pulse name agrees with the field indicator
  a_r7_sof_parity: assert property (@(posedge clk) disable iff (rst)
    (o_sof_odd |-> o_field) and (o_sof_even |-> !o_field));

  // R10: field indicator changes only at a field boundary
  a_r10_field_hold: assert property (@(posedge clk) disable iff (rst)
    ((o_hcnt != '0) || (o_vcnt != '0)) |-> $stable(o_field));

  // R9: composite sync is the union of the two syncs, each polarity removed
  a_r9_csync_merge: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((o_csync ^ $past(inv_cs)) ==
                     ((o_hsync ^ $past(inv_hs)) | (o_vsync ^ $past(inv_vs)))));
endmodule

bind ilace_raster_gen ilace_raster_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .o_hcnt(o_hcnt), .o_vcnt(o_vcnt), .o_de(o_de),
  .o_hsync(o_hsync), .o_vsync(o_vsync), .o_csync(o_csync), .o_field(o_field),
  .o_sof_even(o_sof_even), .o_sof_odd(o_sof_odd),
  .inv_hs(cfg_inv_hs), .inv_vs(cfg_inv_vs), .inv_cs(cfg_inv_cs),
  .cur_hact(cur_hact), .cur_vact(cur_vact)
);

// File: tb/tb_ilace_raster_gen.sv
module tb_ilace_raster_gen;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [31:0]   cfg_active, cfg_total, cfg_hporch, cfg_vporch;
  logic          cfg_ilace, cfg_inv_hs, cfg_inv_vs, cfg_inv_cs;
  logic [HW-1:0] o_hcnt;
  logic [VW-1:0] o_vcnt;
  logic          o_de, o_hsync, o_vsync, o_csync, o_field, o_sof_even, o_sof_odd;

  ilace_raster_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst(rst), .cfg_active(cfg_active), .cfg_total(cfg_total),
    .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch), .cfg_ilace(cfg_ilace),
    .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs), .cfg_inv_cs(cfg_inv_cs),
    .o_hcnt(o_hcnt), .o_vcnt(o_vcnt), .o_de(o_de), .o_hsync(o_hsync),
    .o_vsync(o_vsync), .o_csync(o_csync), .o_field(o_field),
    .o_sof_even(o_sof_even), .o_sof_odd(o_sof_odd)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct {
    int h, v;
    bit de, hs, vs, cs, fld, sofe, sofo;
  } exp_t;
  exp_t q[$];

  // Reference raster from the requirements
  int  mh, mv;
  bit  modd;
  int  p_hact, p_htot, p_hss, p_hse, p_vpos, p_vact, p_vtot, p_vss, p_vse;

  task automatic load_params(input bit odd);
    int inc;
    inc    = odd ? 1 : 0;
    p_hact = int'(cfg_active[15:0]);
    p_vact = int'(cfg_active[31:16]);
    p_htot = int'(cfg_total[15:0]);
    p_vtot = int'(cfg_total[31:16]) + inc;              // R6 longer odd field
    p_hss  = p_hact + int'(cfg_hporch[15:0]);           // R4
    p_hse  = p_htot - int'(cfg_hporch[31:16]);
    p_vss  = p_vact + int'(cfg_vporch[15:0]) + inc;     // R5 / R6
    p_vse  = p_vtot - int'(cfg_vporch[31:16]);
    p_vpos = odd ? p_hss - p_htot / 2 : p_hss;          // R6 half-line shift
  endtask

  task automatic push_expect();
    exp_t e;
    bit ihs, ivs;
    e.h    = mh;
    e.v    = mv;
    e.de   = (mh < p_hact) && (mv < p_vact);
    ihs    = (mh >= p_hss) && (mh < p_hse);
    ivs    = ((mv > p_vss) || (mv == p_vss && mh >= p_vpos)) &&
             ((mv < p_vse) || (mv == p_vse && mh < p_vpos));
    e.hs   = ihs ^ cfg_inv_hs;
    e.vs   = ivs ^ cfg_inv_vs;
    e.cs   = (ihs | ivs) ^ cfg_inv_cs;
    e.fld  = modd;
    e.sofe = (mh == 0) && (mv == 0) && !modd;
    e.sofo = (mh == 0) && (mv == 0) && modd;
    q.push_back(e);
  endtask

  // Driver side of the scoreboard
  always @(posedge clk) begin
    if (rst) begin
      mh = 0; mv = 0; modd = 1'b0;
      load_params(1'b0);
      q.delete();
    end else begin
      push_expect();
      if (mh == p_htot - 1) begin
        mh = 0;
        if (mv == p_vtot - 1) begin
          mv = 0;
          modd = cfg_ilace && !modd;   // R7 / R10
          load_params(modd);
        end else begin
          mv = mv + 1;
        end
      end else begin
        mh = mh + 1;
      end
    end
  end

  // Monitor side
  bit chk_vs_pos = 1'b0;
  bit have_prev = 1'b0;
  bit prev_odd = 1'b0;
  bit prev_vs = 1'b0;
  int since = 0;
  int lat_hss = 0;
  int lat_vss = 0;

  always @(negedge clk) begin
    exp_t e;
    if (rst) begin
      have_prev = 1'b0;
      prev_vs = 1'b0;
    end else if (q.size() > 0) begin
      e = q.pop_front();
      check(int'(o_hcnt) == e.h && int'(o_vcnt) == e.v, "R2 position", int'(o_hcnt) + 10000 * int'(o_vcnt), e.h + 10000 * e.v);
      check(o_de == e.de, "R3 de", o_de, e.de);
      check(o_hsync == e.hs, "R4 hsync", o_hsync, e.hs);
      check(o_vsync == e.vs, "R5 vsync", o_vsync, e.vs);
      check(o_csync == e.cs, "R9 csync", o_csync, e.cs);
      check(o_field == e.fld, "R7 field", o_field, e.fld);
      check(o_sof_even == e.sofe && o_sof_odd == e.sofo, "R8 sof", {o_sof_even, o_sof_odd}, {e.sofe, e.sofo});

      if (o_sof_even || o_sof_odd) begin
        if (have_prev)
          check(since == (prev_odd ? 16 * 11 : 16 * 10), "R6 field length", since, prev_odd ? 176 : 160);
        have_prev = 1'b1;
        prev_odd = o_sof_odd;
        since = 1;
        lat_hss = int'(cfg_active[15:0]) + int'(cfg_hporch[15:0]);
        lat_vss = int'(cfg_active[31:16]) + int'(cfg_vporch[15:0]);
      end else begin
        since++;
      end

      if (chk_vs_pos && o_vsync && !prev_vs) begin
        if (o_field) begin
          check(int'(o_vcnt) == lat_vss + 1, "R6 odd vsync line", o_vcnt, lat_vss + 1);
          check(int'(o_hcnt) == lat_hss - 8, "R6 odd vsync pixel", o_hcnt, lat_hss - 8);
        end else begin
          check(int'(o_vcnt) == lat_vss, "R5 even vsync line", o_vcnt, lat_vss);
          check(int'(o_hcnt) == lat_hss, "R5 even vsync pixel", o_hcnt, lat_hss);
        end
      end
      prev_vs = o_vsync;
    end
  end

  task automatic check_reset();
    check(o_hcnt == '0 && o_vcnt == '0, "R1 counters in reset", int'(o_hcnt) + int'(o_vcnt), 0);
    check({o_de, o_hsync, o_vsync, o_csync, o_field, o_sof_even, o_sof_odd} == 7'b0,
          "R1 outputs in reset", {o_de, o_hsync, o_vsync, o_csync, o_field, o_sof_even, o_sof_odd}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst        = 1'b1;
    cfg_active = {16'd4, 16'd8};
    cfg_total  = {16'd10, 16'd16};
    cfg_hporch = {16'd3, 16'd2};
    cfg_vporch = {16'd2, 16'd2};
    cfg_ilace  = 1'b0;
    cfg_inv_hs = 1'b0;
    cfg_inv_vs = 1'b0;
    cfg_inv_cs = 1'b0;
    repeat (4) @(negedge clk);
    #1 check_reset();                          // R1
    @(negedge clk); #1 rst = 1'b0;
    chk_vs_pos = 1'b1;
    repeat (330) @(negedge clk);               // progressive: every field even (R7)
    #1 cfg_ilace = 1'b1;                       // mid field: R10
    repeat (700) @(negedge clk);
    #1 cfg_hporch = {16'd3, 16'd1};            // mid field margin change: R10, R4
    repeat (700) @(negedge clk);
    chk_vs_pos = 1'b0;
    #1 cfg_inv_hs = 1'b1; cfg_inv_vs = 1'b1; cfg_inv_cs = 1'b1;   // R9
    repeat (400) @(negedge clk);
    #1 cfg_inv_hs = 1'b0; cfg_inv_vs = 1'b0; cfg_inv_cs = 1'b0;
    cfg_ilace = 1'b0;
    repeat (500) @(negedge clk);
    #1 cfg_ilace = 1'b1;
    repeat (420) @(negedge clk);
    #1 rst = 1'b1;                             // reset during interlaced run
    repeat (3) @(negedge clk);
    #1 check_reset();                          // R1
    @(negedge clk); #1 rst = 1'b0;
    repeat (500) @(negedge clk);
    finish_run();
  end
endmodule